// File: doc/BRIEF.md
# Bus Write Capture With Ready Flag

This block watches a slow synchronous 8-bit processor bus from a fast system clock and records every write cycle aimed at one decoded page. A decoder elsewhere drives an active-low page select for that page. When that select is low, the cycle is a write and the phase-2 bus clock is high, the block makes a single-clock capture strobe on the rising edge of that condition. The strobe loads the low address byte and the data byte into holding registers and sets a sticky ready flag.

A slower controller polls the ready flag. It reads the held address as a command code and the held data as its payload, then pulses a clear input. If a second write lands before the clear, the held bytes are overwritten with the newer cycle and a sticky overrun bit records the loss. The bus controls and bus bytes pass through matching synchroniser stages, so the bytes captured are the ones that were on the bus when the qualifying condition was first seen. Capture completes within a few system clocks, well before phase-2 falls and the bus address moves on.

Top module: `wrcap_top`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, the held address, held data, ready flag and overrun bit are all zero.
- R2: A capture happens only when phase-2 is high, the select is low and the read/write line is low (low means write). Read cycles, cycles with the select high, and cycles in which phase-2 never rises leave the held bytes and both flags unchanged.
- R3: A qualifying window captures exactly once, at its start. Bus bytes that change later in the same window, while phase-2 stays high, do not alter the held bytes.
- R4: The held bytes and the ready flag take their new values on the third rising system clock edge after the inputs first meet the qualifying condition (two synchroniser stages plus the holding register), and not on the second.
- R5: Once set, the ready flag stays set, with no further bus activity, until the clear input is asserted.
- R6: A clear asserted for one clock, with no capture strobe in that cycle, drops the ready flag and the overrun bit on the next edge.
- R7: When a capture strobe and a clear fall in the same cycle, the capture wins: the ready flag is set afterwards and the overrun bit is not set.
- R8: A capture while the ready flag is already set (and no clear in that cycle) overwrites both held bytes with the new cycle and sets the overrun bit, which stays set until a clear.
- R9: A clear does not change the held address or held data.
- R10: The overrun bit is never set while the ready flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2_in | input | 1 | Bus phase-2 clock, asynchronous to clk |
| sel_n_in | input | 1 | Active-low page select from the bus decoder |
| bus_rd_in | input | 1 | Bus read/write line, 1 = read, 0 = write |
| addr_in | input | ADDR_W (8) | Low address byte of the bus |
| data_in | input | DATA_W (8) | Bus data byte |
| clr_in | input | 1 | Consumer clear of the ready and overrun flags |
| addr_q | output | ADDR_W (8) | Held address (command code) |
| data_q | output | DATA_W (8) | Held data (payload) |
| ready_q | output | 1 | Sticky capture-ready flag |
| overrun_q | output | 1 | Sticky overrun bit |

## Verification
Every cycle, the assertions check the flag rules: the strobe lasts one clock, ready stays set without a clear, a strobe always leaves ready set, a lone clear empties both flags, a strobe on a full register raises overrun, overrun never stands without ready, and the held bytes move only on a strobe. What the cycle-level properties cannot show is the link from the bus pins to the strobe. That covers the exact three-edge latency, a single capture per long phase-2 window despite changing bytes, the rejection of reads and unselected cycles, and the byte values that end up held. The bench shows these with directed windows and a seeded random mix of bus cycles and clears, compared against its own model.

// File: rtl/wrcap_pkg.sv
package wrcap_pkg;

  // Bus-level qualification: phase-2 high, page selected (active low),
  // write cycle (read line low).
  function automatic logic wr_qualify(input logic phi2, input logic sel_n,
                                      input logic bus_rd);
    return phi2 & ~sel_n & ~bus_rd;
  endfunction

  // Rising-edge detect between the present level and the previous one.
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Next value of the ready flag: a capture beats a clear.
  function automatic logic ready_next(input logic stb, input logic clr,
                                      input logic rdy);
    return stb | (rdy & ~clr);
  endfunction

  // Next value of the overrun bit: set by a capture onto a full register
  // when no clear is present, held until a clear.
  function automatic logic overrun_next(input logic stb, input logic clr,
                                        input logic rdy, input logic ovr);
    return (stb & rdy & ~clr) | (ovr & ~clr);
  endfunction

endpackage

// File: rtl/wrcap_sync.sv
module wrcap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/wrcap_edge.sv
module wrcap_edge
  import wrcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic phi2_s,
  input  logic sel_n_s,
  input  logic bus_rd_s,
  output logic qual,
  output logic cap_stb
);

  logic qual_d;

  assign qual = wr_qualify(phi2_s, sel_n_s, bus_rd_s);

  always_ff @(posedge clk) begin
    if (!rst_n) qual_d <= 1'b0;
    else        qual_d <= qual;
  end

  assign cap_stb = rise_of(qual, qual_d);

endmodule

// File: rtl/wrcap_hold.sv
module wrcap_hold
  import wrcap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stb,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              overrun_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_stb) begin
      addr_q <= addr_s;
      data_q <= data_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      ready_q   <= ready_next(cap_stb, clr, ready_q);
      overrun_q <= overrun_next(cap_stb, clr, ready_q, overrun_q);
    end
  end

endmodule

// File: rtl/wrcap_top.sv
module wrcap_top #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2_in,
  input  logic              sel_n_in,
  input  logic              bus_rd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              clr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              overrun_q
);

  localparam int CTRL_W = 3;
  localparam int BUS_W  = ADDR_W + DATA_W;

  logic [CTRL_W-1:0] ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              phi2_s, sel_n_s, bus_rd_s;
  logic              qual;
  logic              cap_stb;

  // Controls and bus bytes share the same depth so they stay aligned.
  wrcap_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({phi2_in, sel_n_in, bus_rd_in}),
    .q    (ctrl_s)
  );

  wrcap_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_bus_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({addr_in, data_in}),
    .q    (bus_s)
  );

  assign {phi2_s, sel_n_s, bus_rd_s} = ctrl_s;

  wrcap_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .phi2_s  (phi2_s),
    .sel_n_s (sel_n_s),
    .bus_rd_s(bus_rd_s),
    .qual    (qual),
    .cap_stb (cap_stb)
  );

  wrcap_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_stb  (cap_stb),
    .clr      (clr_in),
    .addr_s   (bus_s[BUS_W-1:DATA_W]),
    .data_s   (bus_s[DATA_W-1:0]),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .ready_q  (ready_q),
    .overrun_q(overrun_q)
  );

endmodule

// File: rtl/wrcap_chk.sv
module wrcap_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_stb,
  input logic              clr_in,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] data_q,
  input logic              ready_q,
  input logic              overrun_q
);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> !cap_stb);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> ($stable(addr_q) && $stable(data_q)));

  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !clr_in) |=> ready_q);

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_in && !cap_stb) |=> (!ready_q && !overrun_q));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> ready_q);

  // R8
  overrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && ready_q && !clr_in) |=> overrun_q);

  // R10
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_q |-> ready_q);

endmodule

bind wrcap_top wrcap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_stb  (cap_stb),
  .clr_in   (clr_in),
  .addr_q   (addr_q),
  .data_q   (data_q),
  .ready_q  (ready_q),
  .overrun_q(overrun_q)
);

// File: tb/sim_wrcap_top.sv
module sim_wrcap_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       phi2_in, sel_n_in, bus_rd_in, clr_in;
  logic [7:0] addr_in, data_in;
  logic [7:0] addr_q, data_q;
  logic       ready_q, overrun_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] e_addr, e_data;
  logic       e_ready, e_ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrcap_top u0 (
    .clk(clk), .rst_n(rst_n), .phi2_in(phi2_in), .sel_n_in(sel_n_in),
    .bus_rd_in(bus_rd_in), .addr_in(addr_in), .data_in(data_in),
    .clr_in(clr_in), .addr_q(addr_q), .data_q(data_q),
    .ready_q(ready_q), .overrun_q(overrun_q)
  );

  // Bench view of a qualifying bus cycle: write, page selected, phase-2 seen high.
  function automatic bit takes_write(bit rd, bit seln, int hi_cycles);
    return (rd == 1'b0) && (seln == 1'b0) && (hi_cycles > 0);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " addr"}, addr_q, e_addr);
    chk({tag, " data"}, data_q, e_data);
    chk({tag, " ready"}, {7'd0, ready_q}, {7'd0, e_ready});
    chk({tag, " overrun"}, {7'd0, overrun_q}, {7'd0, e_ovr});
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_cycle(logic [7:0] a, logic [7:0] d, bit rd, bit seln,
                           int hi_cycles);
    addr_in = a; data_in = d; bus_rd_in = rd; sel_n_in = seln; phi2_in = 1'b0;
    tick(1);
    if (hi_cycles > 0) begin
      phi2_in = 1'b1;
      tick(hi_cycles);
      phi2_in = 1'b0;
    end
    tick(4);
    sel_n_in = 1'b1; bus_rd_in = 1'b1;
    if (takes_write(rd, seln, hi_cycles)) begin
      if (e_ready) e_ovr = 1'b1;
      e_ready = 1'b1;
      e_addr = a;
      e_data = d;
    end
  endtask

  task automatic clear_flags();
    clr_in = 1'b1;
    tick(1);
    clr_in = 1'b0;
    tick(1);
    e_ready = 1'b0;
    e_ovr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; phi2_in = 1'b0; sel_n_in = 1'b1; bus_rd_in = 1'b1;
    clr_in = 1'b0; addr_in = 8'h00; data_in = 8'h00;
    e_addr = 8'h00; e_data = 8'h00; e_ready = 1'b0; e_ovr = 1'b0;
    tick(5);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    tick(1);
    chk_all("R1 after reset");

    // R4: latency of exactly three edges
    addr_in = 8'h3C; data_in = 8'hA5; bus_rd_in = 1'b0; sel_n_in = 1'b0;
    phi2_in = 1'b1;
    tick(2);
    chk("R4 not yet ready", {7'd0, ready_q}, 8'd0);
    chk("R4 not yet addr", addr_q, 8'h00);
    tick(1);
    chk("R4 ready on third edge", {7'd0, ready_q}, 8'd1);
    chk("R4 addr on third edge", addr_q, 8'h3C);
    chk("R4 data on third edge", data_q, 8'hA5);
    // R3: bytes change later in the same window
    data_in = 8'h11; addr_in = 8'h22;
    tick(4);
    chk("R3 addr kept", addr_q, 8'h3C);
    chk("R3 data kept", data_q, 8'hA5);
    chk("R3 no overrun", {7'd0, overrun_q}, 8'd0);
    phi2_in = 1'b0; sel_n_in = 1'b1; bus_rd_in = 1'b1;
    tick(4);
    e_addr = 8'h3C; e_data = 8'hA5; e_ready = 1'b1;

    // R5: sticky with no activity
    tick(25);
    chk_all("R5 sticky");

    // R8: second write overruns and overwrites
    bus_cycle(8'h81, 8'h7E, 1'b0, 1'b0, 3);
    chk_all("R8 overrun");

    // R6 and R9: clear drops flags, bytes stay
    clear_flags();
    chk_all("R6 R9 clear");

    // R2: non-qualifying cycles
    bus_cycle(8'h55, 8'h66, 1'b1, 1'b0, 3);
    chk_all("R2 read ignored");
    bus_cycle(8'h57, 8'h68, 1'b0, 1'b1, 3);
    chk_all("R2 unselected ignored");
    bus_cycle(8'h59, 8'h6A, 1'b0, 1'b0, 0);
    chk_all("R2 no phase2 ignored");
    clear_flags();
    chk_all("R9 clear when empty");

    // R7: capture and clear in the same cycle, with ready already set
    bus_cycle(8'h10, 8'h20, 1'b0, 1'b0, 2);
    addr_in = 8'hD5; data_in = 8'hE6; bus_rd_in = 1'b0; sel_n_in = 1'b0;
    phi2_in = 1'b1;
    tick(2);
    clr_in = 1'b1;
    tick(1);
    clr_in = 1'b0;
    phi2_in = 1'b0;
    tick(4);
    sel_n_in = 1'b1; bus_rd_in = 1'b1;
    e_addr = 8'hD5; e_data = 8'hE6; e_ready = 1'b1; e_ovr = 1'b0;
    chk_all("R7 set wins");
    clear_flags();
    chk_all("R6 clear after R7");

    // Seeded random mix
    for (int i = 0; i < 120; i++) begin
      logic [7:0] ra, rdv;
      bit rrd, rsel;
      int rhi;
      ra = 8'($urandom);
      rdv = 8'($urandom);
      rrd = ($urandom % 3) == 0;
      rsel = ($urandom % 4) == 0;
      rhi = int'($urandom % 5);
      bus_cycle(ra, rdv, rrd, rsel, rhi);
      chk_all("R2 R8 random bus");
      if (($urandom % 4) == 0) begin
        clear_flags();
        chk_all("R6 random clear");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule